// File: doc/BRIEF.md
# Address Mirroring Folding Unit

This block maps a 28-bit bus address onto the valid offset range of a memory region whose size need not be a power of two. The region then repeats across its whole address window. For a size such as 96K, a plain mask cannot do this. The unit instead removes set address bits one at a time, from the top bit down. When the size is larger than the removed bit, it moves that bit into an accumulated base. When the remaining address falls below the remaining size, the offset is that base plus the remainder.

The unit works iteratively and inspects one address bit per clock. A one-cycle start strobe captures the address and the size. After that the inputs may change freely. A one-cycle done pulse marks the cycle in which the new offset is first presented. The offset holds until the next done pulse. The unit does not decode regions, does not perform any access and does not account for wait states.

Top module: `mirror_fold`

## Requirements
- R1: While rst_n is low, and in the first cycle after its release, done is 0 and offset is 0.
- R2: A size of zero yields offset 0, with done high in the cycle after the second rising edge counted from the edge that samples start.
- R3: An address already below a nonzero size is returned unchanged as the offset, with done high after the second rising edge counted from the start edge.
- R4: For any other address and size, offset equals the result of the folding procedure. A working address, size and base start as (addr, size, 0) and a bit position starts at 27. While address ≥ size: step down to the next set address bit; subtract it from the address; if size exceeds that bit value, subtract it from size and add it to base; then go one position lower. The result is base + address. Each position visited costs one clock beyond the first.
- R5: When the size is a power of two, offset equals addr & (size − 1).
- R6: done is high for exactly one cycle per accepted start.
- R7: A start seen while a fold is in progress is ignored. Changing addr_in or size_in after the start edge does not affect the result.
- R8: done rises no more than ADDR_W+1 rising edges after the edge that accepts start.
- R9: With a nonzero size, every offset is below the size. offset changes only in a cycle where done is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a fold with the present addr_in and size_in (accepted when idle) |
| addr_in | input | 28 | Bus address to fold |
| size_in | input | 28 | Region size in bytes; 0 means an empty region |
| done | output | 1 | One-cycle pulse: offset holds a new result |
| offset | output | 28 | Folded offset inside the region |

## Verification
The bench targets sizes just above and below a power of two, where a design that compares the size with `>=` instead of `>` gives the wrong base. It also targets a zero size, which would hang a design with no empty-region exit. Addresses with long runs of clear bits test the scan: an off-by-one there shifts the latency and the done pulse lands a cycle early or late. The bench also raises start and changes the inputs while a fold is running. A design that reloads on that start, or reads the live inputs, returns the wrong offset.

// File: rtl/mirror_pkg.sv
package mirror_pkg;

  typedef enum logic {
    FOLD_IDLE = 1'b0,
    FOLD_SCAN = 1'b1
  } fold_state_e;

endpackage

// File: rtl/mirror_ctrl.sv
module mirror_ctrl
  import mirror_pkg::*;
#(
  parameter int ADDR_W = 28,
  localparam int IDX_W = $clog2(ADDR_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             below,
  output logic             load,
  output logic             step,
  output logic             finish,
  output logic             busy,
  output logic [IDX_W-1:0] idx
);

  fold_state_e state_q;

  assign busy   = (state_q == FOLD_SCAN);
  assign load   = !busy && start;
  assign finish = busy && below;
  assign step   = busy && !below;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= FOLD_IDLE;
      idx     <= '0;
    end else if (load) begin
      state_q <= FOLD_SCAN;
      idx     <= IDX_W'(ADDR_W - 1);
    end else if (finish) begin
      state_q <= FOLD_IDLE;
    end else if (step) begin
      idx     <= idx - 1'b1;
    end
  end

endmodule

// File: rtl/mirror_path.sv
module mirror_path #(
  parameter int ADDR_W = 28,
  localparam int IDX_W = $clog2(ADDR_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [IDX_W-1:0]  idx,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [ADDR_W-1:0] size_in,
  output logic              below,
  output logic [ADDR_W-1:0] sum
);

  logic [ADDR_W-1:0] wa_q, ws_q, wb_q;
  logic [ADDR_W-1:0] wa_n, ws_n, wb_n;

  // One position of the scan: strip the bit if set, move it to base if the size allows.
  function automatic logic [3*ADDR_W-1:0] fold_bit(
    input logic [ADDR_W-1:0] a,
    input logic [ADDR_W-1:0] s,
    input logic [ADDR_W-1:0] b,
    input logic [IDX_W-1:0]  pos
  );
    logic [ADDR_W-1:0] weight;
    weight = {{(ADDR_W-1){1'b0}}, 1'b1} << pos;
    if (a[pos]) begin
      a = a - weight;
      if (s > weight) begin
        s = s - weight;
        b = b + weight;
      end
    end
    return {a, s, b};
  endfunction

  assign {wa_n, ws_n, wb_n} = fold_bit(wa_q, ws_q, wb_q, idx);

  assign below = (ws_q == '0) || (wa_q < ws_q);
  assign sum   = wb_q + wa_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wa_q <= '0;
      ws_q <= '0;
      wb_q <= '0;
    end else if (load) begin
      wa_q <= (size_in == '0) ? '0 : addr_in;
      ws_q <= size_in;
      wb_q <= '0;
    end else if (step) begin
      wa_q <= wa_n;
      ws_q <= ws_n;
      wb_q <= wb_n;
    end
  end

endmodule

// File: rtl/mirror_fold.sv
module mirror_fold #(
  parameter int ADDR_W = 28,
  localparam int IDX_W = $clog2(ADDR_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [ADDR_W-1:0] size_in,
  output logic              done,
  output logic [ADDR_W-1:0] offset
);

  logic             load, step, finish, busy, below;
  logic [IDX_W-1:0] idx;
  logic [ADDR_W-1:0] sum;

  mirror_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .below  (below),
    .load   (load),
    .step   (step),
    .finish (finish),
    .busy   (busy),
    .idx    (idx)
  );

  mirror_path #(.ADDR_W(ADDR_W)) u_path (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .step    (step),
    .idx     (idx),
    .addr_in (addr_in),
    .size_in (size_in),
    .below   (below),
    .sum     (sum)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done   <= 1'b0;
      offset <= '0;
    end else begin
      done <= finish;
      if (finish) offset <= sum;
    end
  end

endmodule

// File: rtl/mirror_fold_chk.sv
module mirror_fold_chk #(
  parameter int ADDR_W = 28
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] size_in,
  input logic              done,
  input logic [ADDR_W-1:0] offset,
  input logic              busy
);

  logic [ADDR_W-1:0] cap_addr, cap_size;
  logic [7:0]        run_len;
  logic              cap_pow2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_addr <= '0;
      cap_size <= '0;
      run_len  <= '0;
    end else begin
      if (start && !busy) begin
        cap_addr <= addr_in;
        cap_size <= size_in;
      end
      run_len <= busy ? run_len + 8'd1 : 8'd0;
    end
  end

  assign cap_pow2 = (cap_size != '0) && ((cap_size & (cap_size - 1'b1)) == '0);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_ZERO_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_size == '0) |-> offset == '0); // R2
  AST_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_size != '0) |-> offset < cap_size); // R9
  AST_HOLD_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(offset)); // R9
  AST_POW2_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_pow2) |-> offset == (cap_addr & (cap_size - 1'b1))); // R5
  AST_LAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run_len <= 8'(ADDR_W)); // R8

endmodule

bind mirror_fold mirror_fold_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .addr_in (addr_in),
  .size_in (size_in),
  .done    (done),
  .offset  (offset),
  .busy    (busy)
);

// File: tb/sim_mirror_fold.sv
`timescale 1ns/1ps
module sim_mirror_fold;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [27:0] addr_in = '0;
  logic [27:0] size_in = '0;
  logic        done;
  logic [27:0] offset;

  int    n_checks = 0;
  int    n_errors = 0;
  string cur_req  = "R1";
  bit    finished = 1'b0;

  always #2 clk = ~clk;

  mirror_fold u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .addr_in(addr_in), .size_in(size_in),
    .done(done), .offset(offset)
  );

  // Behavioural folding: integer arithmetic, counts bit positions visited.
  task automatic ref_fold(input longint a_in, input longint s_in,
                          output longint res, output int visits);
    longint a = a_in, s = s_in, base = 0;
    int p = 27;
    visits = 0;
    res = 0;
    if (s != 0) begin
      while (a >= s) begin
        while (((a >> p) & 1) == 0) p--;
        a -= (longint'(1) << p);
        if (s > (longint'(1) << p)) begin
          s    -= (longint'(1) << p);
          base += (longint'(1) << p);
        end
        p--;
      end
      visits = 27 - p;
      res = base + a;
    end
  endtask

  // Cycle model
  bit     m_busy = 0, m_done = 0;
  int     m_cnt = 0, m_lat = 0;
  longint m_res = 0, m_off = 0;
  longint last_size = 0, last_addr = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_cnt = 0; m_off = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_lat++;
        if (m_cnt == 0) begin
          m_busy = 0; m_done = 1; m_off = m_res;
        end else m_cnt--;
      end else if (start) begin
        m_busy = 1; m_lat = 0;
        last_addr = addr_in; last_size = size_in;
        ref_fold(addr_in, size_in, m_res, m_cnt);
      end
    end
  end

  task automatic fail_line(string req, longint act, longint exp);
    n_errors++;
    $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      n_checks++;
      if (done !== m_done) fail_line({cur_req, " done"}, done, m_done);
      n_checks++;
      if (offset !== m_off[27:0]) fail_line({cur_req, " offset"}, offset, m_off);
      if (m_done && rst_n) begin
        n_checks++; // R8
        if (m_lat > 29) fail_line("R8 latency", m_lat, 29);
        if (last_size != 0) begin
          n_checks++; // R9
          if (offset >= last_size) fail_line("R9 range", offset, last_size);
        end
        if (last_size != 0 && (last_size & (last_size - 1)) == 0) begin
          n_checks++; // R5
          if (offset !== (last_addr & (last_size - 1)))
            fail_line("R5 pow2", offset, last_addr & (last_size - 1));
        end
        if (last_size == 0) begin
          n_checks++; // R2
          if (offset !== 0) fail_line("R2 zero", offset, 0);
        end
      end
    end
  end

  task automatic run_one(input logic [27:0] a, input logic [27:0] s, input bit poke);
    @(negedge clk);
    start = 1; addr_in = a; size_in = s;
    @(negedge clk);
    start = 0;
    addr_in = 28'($urandom); size_in = 28'($urandom);
    if (poke) begin // R7: restart attempt while busy
      start = 1;
      @(negedge clk);
      start = 0;
    end
    while (!m_done) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_errors++; n_checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R2";
    run_one(28'h0ABCDEF, 28'h0, 0);
    run_one(28'hFFFFFFF, 28'h0, 0);
    cur_req = "R3";
    run_one(28'h0000123, 28'h0018000, 0);
    run_one(28'h0017FFF, 28'h0018000, 0);
    cur_req = "R5";
    for (int k = 0; k < 28; k++) run_one(28'($urandom), 28'(1) << k, 0);
    cur_req = "R4";
    run_one(28'h2018000, 28'h0018000, 0);
    run_one(28'hFFFFFFF, 28'h0018000, 0);
    run_one(28'h8000000, 28'h0000003, 0);
    run_one(28'hFFFFFFF, 28'h8000001, 0);
    run_one(28'h7FFFFFF, 28'h4000001, 0);
    run_one(28'h0000001, 28'h0000001, 0);
    cur_req = "R7";
    for (int k = 0; k < 20; k++) run_one(28'($urandom), 28'($urandom) >> (k % 28), 1);
    cur_req = "R4";
    for (int k = 0; k < 300; k++) begin
      logic [27:0] s;
      case (k % 4)
        0: s = 28'($urandom);
        1: s = 28'($urandom) >> ($urandom % 28);
        2: s = (28'(1) << ($urandom % 27)) + 28'($urandom % 3);
        default: s = (28'(1) << ($urandom % 27)) - 28'(1);
      endcase
      run_one(28'($urandom), s, 0);
    end
    cur_req = "R6";
    repeat (4) @(negedge clk);
    summary();
  end

endmodule